// File: doc/BRIEF.md
# Reset Cause and Request Register

This block is a single 32-bit register in a memory-mapped configuration space. It records why the system last came out of reset, and it gives software a way to ask for a new system reset. Five cause flags sit in the top five bits. From bit 31 down, they are: power-on, software power-on, software externally initiated reset, button power-on, and button externally initiated reset. Bits 26 to 0 do not exist. They read as zero, and writes to them have no effect.

A saturating counter of system resets lives beside the register. It survives every system reset and is cleared only by the power-up reset input. At a system reset, the register is loaded with only the power-on flag if the counter is zero; otherwise the register keeps its contents. When software writes the software power-on flag, the counter goes back to zero, so the reset that follows is handled as a fresh power-on. The reset sequencer itself is outside the block. This block only emits a one-cycle request pulse to it.

The register is the upper 32-bit word of an 8-byte slot, at byte offset 4. The lower word of the slot reads zero and ignores writes. Every address outside the slot does the same.

Top module: `rst_cause_reg`

## Requirements
- R1: After the power-up reset input (pwr_rst_n low), the register reads 0, rst_req is 0, and the reset counter is 0.
- R2: A system reset (sys_rst high for one clock) while the counter is 0 loads the register with 0x80000000. Only bit 31 is set.
- R3: A system reset while the counter is nonzero leaves the register unchanged. Every system reset increments the counter.
- R4: Write data is masked with 0xF8000000 before use. Bits 26:0 always read 0.
- R5: Bits 31, 28 and 27 are write-one-to-clear. Writing 0 to them changes nothing, and a write can never set them.
- R6: Bits 30 and 29 are set by writing 1. Writing 0 to them leaves them unchanged.
- R7: A write with bit 30 set clears the counter and requests a reset. The next system reset therefore reloads 0x80000000.
- R8: A write with bit 29 set and bit 30 clear requests a reset and leaves the counter untouched.
- R9: rst_req is high for exactly the one cycle after the clock edge that accepts a write containing bit 30 or bit 29. It is low at all other times.
- R10: The register sits at byte offset 4 of the 8-byte slot at SLOT_ADDR, selected by addr[2] = 1. The lower word (addr[2] = 0) and all other addresses read 0 and ignore writes.
- R11: The counter saturates at its maximum value (2^CNT_W - 1) and does not wrap. However long a run of system resets is, it never reloads the register after the first.
- R12: When a write and a system reset fall in the same cycle, the system reset wins. The write is dropped and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Asynchronous power-up reset, active low; clears register and counter |
| sys_rst | input | 1 | Synchronous system-reset event, one cycle per reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational from addr) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The main stimulus is a sweep over all 32 values of the five implemented bits, written on top of the post-power-on state with every unimplemented bit driven to 1. This one sweep separates the clear-only bits from the set-only bits and confirms the masking of the lower bits. A system reset follows each write. It shows whether that write cleared the counter (the register reloads) or left the counter alone (the register is kept). A lower-word write, an out-of-slot write and a write in the same cycle as a system reset each check that nothing is altered. A run of sixteen resets, followed by a cleared flag and one more reset, tells a saturating counter apart from one that wraps.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SLOT_ADDR = 16'hF020,
  parameter int              CNT_W     = 4
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rst_req
);
  localparam int              FLAG_W  = 5;
  localparam int              LOW_W   = 32 - FLAG_W;
  localparam logic [FLAG_W-1:0] CLR_M = 5'b10011;
  localparam logic [FLAG_W-1:0] SET_M = 5'b01100;
  localparam logic [FLAG_W-1:0] POR_V = 5'b10000;
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};

  logic [FLAG_W-1:0] flags;
  logic [CNT_W-1:0]  cnt;
  logic              req_q;

  wire               sel_hi = (addr[ADDR_W-1:3] == SLOT_ADDR[ADDR_W-1:3]) && addr[2];
  wire               wr_hi  = wr_en && sel_hi && !sys_rst;
  wire [FLAG_W-1:0]  wv     = wdata[31:LOW_W];

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      flags <= '0;
      cnt   <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= wr_hi && (wv[3] || wv[2]);
      if (sys_rst) begin
        if (cnt == '0) flags <= POR_V;
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else if (wr_hi) begin
        flags <= (flags & ~(wv & CLR_M)) | (wv & SET_M);
        if (wv[3]) cnt <= '0;
      end
    end
  end

  assign rdata   = sel_hi ? {flags, {LOW_W{1'b0}}} : 32'h0;
  assign rst_req = req_q;

  a_r2_first_load: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && cnt == '0) |=> (flags == POR_V));

  a_r3_kept: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && cnt != '0) |=> $stable(flags));

  a_r7_cnt_clear: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_en && sel_hi && !sys_rst && wdata[30]) |=> (cnt == '0 && rst_req));

  a_r9_req_cause: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_req |-> $past(wr_en && sel_hi && !sys_rst && (wdata[30] || wdata[29])));

  a_r10_lo_ignored: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_en && !sel_hi && !sys_rst) |=> ($stable(flags) && !rst_req));

  a_r11_saturate: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  a_r12_rst_wins: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst && wr_en) |=> !rst_req);
endmodule

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SLOT = 16'hF020;
  localparam logic [15:0] HI   = SLOT + 16'd4;
  localparam logic [15:0] LO   = SLOT;

  logic        clk = 1'b0;
  logic        pwr_rst_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = HI;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  rst_cause_reg #(.ADDR_W(16), .SLOT_ADDR(SLOT), .CNT_W(4)) uut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst(sys_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic por();
    @(negedge clk) pwr_rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) pwr_rst_n = 1'b1;
  endtask

  task automatic sysrst();
    @(negedge clk) sys_rst = 1'b1;
    @(negedge clk) sys_rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk) begin wr_en = 1'b1; addr = a; wdata = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  initial begin
    logic [31:0] d, w, exp;
    por();
    rd(HI, d); chk("R1 reset value", d, 32'h0);
    chk("R1 no request", {31'b0, rst_req}, 32'h0);
    sysrst();
    rd(HI, d); chk("R2 first reset loads", d, 32'h8000_0000);
    wr(HI, 32'h8000_0000);
    rd(HI, d); chk("R5 clear bit31", d, 32'h0);
    sysrst();
    rd(HI, d); chk("R3 later reset keeps", d, 32'h0);

    for (int v = 0; v < 32; v++) begin
      por();
      sysrst();
      wr(LO, 32'hFFFF_FFFF);
      rd(HI, d); chk("R10 lower write ignored", d, 32'h8000_0000);
      rd(LO, d); chk("R10 lower reads zero", d, 32'h0);
      chk("R10 lower no request", {31'b0, rst_req}, 32'h0);
      w = (32'(v) << 27) | 32'h07FF_FFFF;
      wr(HI, w);
      exp = (32'h8000_0000 & ~(w & 32'h9800_0000)) | (w & 32'h6000_0000);
      rd(HI, d); chk("R4 R5 R6 write result", d, exp);
      chk("R9 request pulse", {31'b0, rst_req}, {31'b0, (w[30] | w[29])});
      @(negedge clk);
      chk("R9 pulse one cycle", {31'b0, rst_req}, 32'h0);
      sysrst();
      rd(HI, d);
      if (w[30]) chk("R7 counter cleared reload", d, 32'h8000_0000);
      else       chk("R8 counter kept", d, exp);
    end

    por();
    for (int i = 0; i < 16; i++) sysrst();
    wr(HI, 32'h8000_0000);
    sysrst();
    rd(HI, d); chk("R11 saturating counter", d, 32'h0);

    por();
    sysrst();
    @(negedge clk) begin sys_rst = 1'b1; wr_en = 1'b1; addr = HI; wdata = 32'hC000_0000; end
    @(negedge clk) begin sys_rst = 1'b0; wr_en = 1'b0; end
    rd(HI, d); chk("R12 reset beats write", d, 32'h8000_0000);
    chk("R12 no request", {31'b0, rst_req}, 32'h0);

    wr(16'hF000, 32'hE000_0000);
    rd(HI, d); chk("R10 other address ignored", d, 32'h8000_0000);
    rd(16'hF000, d); chk("R10 other address reads zero", d, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule